// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block counts position from a two-wire encoder (inputs A and B) into a 32-bit register. Software picks one of four count sources: full-resolution quadrature, pulse plus direction, up-only or down-only. In the single-direction modes, a rate bit chooses whether input A counts on rising edges only or on both edges. The counter wraps against a programmable maximum in both directions, and a global enable gates every count.

Both inputs pass through a two-flop synchroniser and a glitch filter. A quadrature phase tracker then turns filtered input changes into count steps. The tracker is a four-state machine, PH_00, PH_01, PH_10 and PH_11, whose states name the last filtered {A,B} levels. Three kinds of transition leave a state:

- **forward**: the next state in the sequence PH_00→PH_10→PH_11→PH_01→PH_00.
- **backward**: the reverse of that sequence.
- **opposite**: both inputs flip at once, which is illegal in quadrature mode.

Staying in the same state counts nothing. A small register port reads and writes the count, the maximum and the two control words.

Top module: `qpos_counter`

## Requirements
- R1: After reset:
  - the count reads 0 and the maximum reads 0xFFFFFFFF;
  - the mode is quadrature (0), the rate bit is 0 and the enable is 0;
  - pos_dir and phase_err are 0.
- R2: The mode field sits at bits 15:14 of the decoder word (address 2). Mode 0 is quadrature. Every forward transition adds one to the count and every backward transition subtracts one, giving four counts per input cycle.
- R3: In mode 0, an opposite transition (A and B change in the same filtered sample) leaves the count unchanged and sets phase_err. phase_err then stays set until reset.
- R4: Mode 1 is pulse/direction. Only a rising edge of A counts: up when B is high, down when B is low. Edges of B alone do not count.
- R5: Mode 2 counts up and mode 3 counts down. With the rate bit (bit 11 of the decoder word) clear, only rising edges of A count, and B has no effect.
- R6: With the rate bit set in mode 2 or 3, both rising and falling edges of A count.
- R7: The maximum is at address 1. Counting up from the maximum gives 0, and counting down from 0 gives the maximum.
- R8: When the enable bit (bit 3 of the control word, address 3) is 0, input edges leave the count unchanged.
- R9: The count is at address 0 and can be read and written. A write whose value exceeds the maximum is ignored.
- R10: If a count write and a count step fall in the same cycle, the written value is kept and the step is dropped.
- R11: pos_dir shows the direction of the most recent counted step (1 = up, 0 = down).
- R12: An input level that lasts fewer than FILT_CYC consecutive synchronised samples produces no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder input A (asynchronous) |
| enc_b | input | 1 | Encoder input B (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 count, 1 maximum, 2 decoder word, 3 control word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pos_dir | output | 1 | Direction of last counted step |
| phase_err | output | 1 | Sticky quadrature phase error |

## Verification
The following are checked on every cycle by the bound checker:
- the count holds while disabled;
- writes above the maximum are refused and in-range writes land exactly;
- an up step from the maximum lands on 0 and an up step below it adds exactly one;
- the phase error flag never clears once set.

Only the bench's scenarios can show the rest:
- the mapping from encoder waveforms to steps in each mode;
- the effect of the rate bit;
- the rejection of short glitches by the filter;
- the write winning over a step that lands in the same cycle.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
    typedef enum logic [1:0] {
        MODE_QUAD = 2'd0,
        MODE_DIR  = 2'd1,
        MODE_UP   = 2'd2,
        MODE_DOWN = 2'd3
    } src_mode_e;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    localparam logic [1:0] ADDR_CNT = 2'd0;
    localparam logic [1:0] ADDR_MAX = 2'd1;
    localparam logic [1:0] ADDR_DEC = 2'd2;
    localparam logic [1:0] ADDR_CTL = 2'd3;
    localparam int MODE_LSB = 14;
    localparam int RATE_BIT = 11;
    localparam int EN_BIT   = 3;
endpackage

// File: rtl/qpos_in_filt.sv
module qpos_in_filt #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic s1, s2;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            run_q <= '0;
            clean <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            if (s2 != clean) begin
                if (run_q == LAST) begin
                    clean <= s2;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/qpos_step_dec.sv
module qpos_step_dec
    import qpos_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  src_mode_e mode,
    input  logic      rate,
    input  logic      fa,
    input  logic      fb,
    output logic      step,
    output logic      step_up,
    output logic      illegal
);
    phase_e state_q, seen;
    phase_e fwd_ph, bwd_ph, opp_ph;
    logic a_rise, a_fall;

    assign seen   = phase_e'({fa, fb});
    assign a_rise = fa && !state_q[1];
    assign a_fall = !fa && state_q[1];

    // state register: always tracks the filtered levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= seen;
    end

    // outputs: classify the transition and form the step
    always_comb begin
        unique case (state_q)
            PH_00: begin fwd_ph = PH_10; bwd_ph = PH_01; opp_ph = PH_11; end
            PH_10: begin fwd_ph = PH_11; bwd_ph = PH_00; opp_ph = PH_01; end
            PH_11: begin fwd_ph = PH_01; bwd_ph = PH_10; opp_ph = PH_00; end
            PH_01: begin fwd_ph = PH_00; bwd_ph = PH_11; opp_ph = PH_10; end
        endcase
        step    = 1'b0;
        step_up = 1'b0;
        illegal = 1'b0;
        unique case (mode)
            MODE_QUAD: begin
                step    = (seen == fwd_ph) || (seen == bwd_ph);
                step_up = (seen == fwd_ph);
                illegal = (seen == opp_ph);
            end
            MODE_DIR: begin
                step    = a_rise;
                step_up = fb;
            end
            MODE_UP: begin
                step    = a_rise || (rate && a_fall);
                step_up = 1'b1;
            end
            MODE_DOWN: begin
                step    = a_rise || (rate && a_fall);
                step_up = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
    import qpos_pkg::*;
#(
    parameter int CW       = 32,
    parameter int FILT_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enc_a,
    input  logic        enc_b,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pos_dir,
    output logic        phase_err
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw, flt;
    logic [CW-1:0]  count_q, max_q;
    src_mode_e      mode_q;
    logic           rate_q, ctl_en;
    logic           step, step_up, illegal, cnt_wr;

    assign raw = {enc_a, enc_b};

    for (genvar g = 0; g < NCH; g++) begin : g_in
        qpos_in_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk(clk), .rst_n(rst_n), .pin(raw[g]), .clean(flt[g])
        );
    end

    qpos_step_dec u_dec (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .rate(rate_q),
        .fa(flt[1]), .fb(flt[0]),
        .step(step), .step_up(step_up), .illegal(illegal)
    );

    assign cnt_wr = reg_wr && (reg_addr == ADDR_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q  <= '1;
            mode_q <= MODE_QUAD;
            rate_q <= 1'b0;
            ctl_en <= 1'b0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADDR_MAX: max_q <= reg_wdata[CW-1:0];
                ADDR_DEC: begin
                    mode_q <= src_mode_e'(reg_wdata[MODE_LSB+1:MODE_LSB]);
                    rate_q <= reg_wdata[RATE_BIT];
                end
                ADDR_CTL: ctl_en <= reg_wdata[EN_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            pos_dir   <= 1'b0;
            phase_err <= 1'b0;
        end else begin
            if (ctl_en && illegal) phase_err <= 1'b1;
            if (cnt_wr) begin
                if (reg_wdata[CW-1:0] <= max_q) count_q <= reg_wdata[CW-1:0];
            end else if (ctl_en && step) begin
                pos_dir <= step_up;
                if (step_up) count_q <= (count_q == max_q) ? '0 : count_q + 1'b1;
                else         count_q <= (count_q == '0) ? max_q : count_q - 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CNT: reg_rdata[CW-1:0] = count_q;
            ADDR_MAX: reg_rdata[CW-1:0] = max_q;
            ADDR_DEC: begin
                reg_rdata[MODE_LSB+1:MODE_LSB] = mode_q;
                reg_rdata[RATE_BIT] = rate_q;
            end
            ADDR_CTL: reg_rdata[EN_BIT] = ctl_en;
        endcase
    end
endmodule

// File: rtl/qpos_counter_chk.sv
module qpos_counter_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_wr,
    input logic [31:0]   wdata,
    input logic [CW-1:0] max_q,
    input logic [CW-1:0] count,
    input logic          en,
    input logic          step,
    input logic          step_up,
    input logic          err
);
    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(count));
    // R9
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && (wdata[CW-1:0] > max_q)) |=> $stable(count));
    // R10
    good_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && (wdata[CW-1:0] <= max_q)) |=> (count == $past(wdata[CW-1:0])));
    // R7
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && step_up && !cnt_wr && count == max_q) |=> (count == '0));
    // R2
    inc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && step_up && !cnt_wr && count < max_q) |=> (count == $past(count) + 1'b1));
    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind qpos_counter qpos_counter_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(reg_wdata),
    .max_q(max_q), .count(count_q), .en(ctl_en), .step(step),
    .step_up(step_up), .err(phase_err)
);

// File: tb/qpos_counter_tb.sv
module qpos_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pos_dir, phase_err;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qpos_counter u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pos_dir(pos_dir), .phase_err(phase_err)
    );

    // {mode, rate, a, b, exp_dir, exp_count}
    localparam logic [13:0] VEC [28] = '{
        {2'd0,1'b0,1'b1,1'b0,1'b1,8'd1}, {2'd0,1'b0,1'b1,1'b1,1'b1,8'd2},
        {2'd0,1'b0,1'b0,1'b1,1'b1,8'd3}, {2'd0,1'b0,1'b0,1'b0,1'b1,8'd4},
        {2'd0,1'b0,1'b0,1'b1,1'b0,8'd3}, {2'd0,1'b0,1'b1,1'b1,1'b0,8'd2},
        {2'd0,1'b0,1'b1,1'b0,1'b0,8'd1}, {2'd0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {2'd0,1'b0,1'b0,1'b1,1'b0,8'd9}, {2'd0,1'b0,1'b0,1'b0,1'b1,8'd0},
        {2'd1,1'b0,1'b0,1'b1,1'b1,8'd0}, {2'd1,1'b0,1'b1,1'b1,1'b1,8'd1},
        {2'd1,1'b0,1'b0,1'b1,1'b1,8'd1}, {2'd1,1'b0,1'b0,1'b0,1'b1,8'd1},
        {2'd1,1'b0,1'b1,1'b0,1'b0,8'd0}, {2'd1,1'b0,1'b0,1'b0,1'b0,8'd0},
        {2'd2,1'b0,1'b1,1'b0,1'b1,8'd1}, {2'd2,1'b0,1'b0,1'b0,1'b1,8'd1},
        {2'd2,1'b0,1'b0,1'b1,1'b1,8'd1}, {2'd2,1'b0,1'b0,1'b0,1'b1,8'd1},
        {2'd2,1'b1,1'b1,1'b0,1'b1,8'd2}, {2'd2,1'b1,1'b0,1'b0,1'b1,8'd3},
        {2'd3,1'b1,1'b1,1'b0,1'b0,8'd2}, {2'd3,1'b1,1'b0,1'b0,1'b0,8'd1},
        {2'd3,1'b0,1'b1,1'b0,1'b0,8'd0}, {2'd3,1'b0,1'b0,1'b0,1'b0,8'd0},
        {2'd3,1'b0,1'b1,1'b0,1'b0,8'd9}, {2'd3,1'b0,1'b0,1'b0,1'b0,8'd9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic rd_cnt(input string req, input logic [31:0] exp);
        reg_addr = 2'd0;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_cnt("R1 count", 32'd0);
        reg_addr = 2'd1; #1; chk("R1 max", reg_rdata, 32'hFFFF_FFFF);
        reg_addr = 2'd2; #1; chk("R1 dec", reg_rdata, 32'd0);
        reg_addr = 2'd3; #1; chk("R1 ctl", reg_rdata, 32'd0);
        chk("R1 dir", {31'd0, pos_dir}, 32'd0);
        chk("R1 err", {31'd0, phase_err}, 32'd0);

        wr(2'd1, 32'd9);
        reg_addr = 2'd1; #1; chk("R7 max readback", reg_rdata, 32'd9);
        wr(2'd3, 32'h8);

        // table: R2 R4 R5 R6 R7 R11
        foreach (VEC[i]) begin
            wr(2'd2, ({30'd0, VEC[i][13:12]} << 14) | ({31'd0, VEC[i][11]} << 11));
            enc_a = VEC[i][10]; enc_b = VEC[i][9];
            settle();
            rd_cnt($sformatf("R2/R4/R5/R6/R7 step %0d", i), {24'd0, VEC[i][7:0]});
            chk($sformatf("R11 dir step %0d", i), {31'd0, pos_dir}, {31'd0, VEC[i][8]});
        end

        // R9 rejected and accepted writes
        wr(2'd0, 32'd20);
        rd_cnt("R9 write above max", 32'd9);
        wr(2'd0, 32'd7);
        rd_cnt("R9 write in range", 32'd7);

        // R8 disabled: edges ignored
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h8000);
        enc_a = 1'b1; settle();
        enc_a = 1'b0; settle();
        rd_cnt("R8 disabled hold", 32'd7);
        wr(2'd3, 32'h8);

        // R12 one-cycle glitch
        @(negedge clk); enc_a = 1'b1;
        @(negedge clk); enc_a = 1'b0;
        settle();
        rd_cnt("R12 glitch rejected", 32'd7);

        // R10 write in the same cycle as a step
        @(negedge clk); enc_a = 1'b1;
        repeat (5) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd3;
        @(negedge clk); reg_wr = 1'b0;
        settle();
        rd_cnt("R10 write wins", 32'd3);
        enc_a = 1'b0; settle();

        // R3 illegal quadrature transition
        wr(2'd2, 32'h0);
        enc_a = 1'b1; enc_b = 1'b1; settle();
        rd_cnt("R3 no count", 32'd3);
        chk("R3 err set", {31'd0, phase_err}, 32'd1);
        enc_a = 1'b0; enc_b = 1'b0; settle();
        wr(2'd3, 32'h8);
        chk("R3 err sticky", {31'd0, phase_err}, 32'd1);

        done = 1'b1;
        finish_up();
    end
endmodule